// File: doc/BRIEF.md
# Column-Parallel AES-128 Encryption Engine

This block encrypts one 128-bit block under a 128-bit key with the AES-128 cipher. Its datapath is 32 bits wide and handles one state column per clock. In that clock, four byte substitution units, the row rotation and the column mixing all work on one column. The row rotation costs no cycle of its own. The four bytes that feed a column are taken straight from the diagonal of the stored state: new column c takes row r from old column (c + r) mod 4. The round keys are expanded on the fly, one 32-bit key word per cycle, in step with the column being computed.

A caller presents a key and a plaintext with a one-cycle start pulse while the engine is idle. After ten rounds of four cycles each, the ciphertext comes out as four 32-bit words on consecutive cycles, flagged by a valid strobe. The whole block takes 44 cycles. The results of finished columns go to a shadow register, so the columns still unread in the current round stay intact until the round commits.

Top module: `aes_col_core`

## Requirements
- R1: After reset, busy_o and out_valid_o are low and out_word_o is zero.
- R2: A start_i pulse sampled high at a rising edge while busy_o is low captures key_i and pt_i, and busy_o is high from that edge until 44 edges later.
- R3: out_valid_o is high after edges 40, 41, 42 and 43 counted from the accepting edge, and low at all other times.
- R4: The four output words come out most significant first: the first word is ciphertext bits 127:96, and the last is bits 31:0.
- R5: The ciphertext equals AES-128 encryption of pt_i under key_i, with byte 0 of the block in bits 127:120.
- R6: A start_i pulse while busy_o is high is ignored: the running block's result and timing do not change.
- R7: out_word_o is zero whenever out_valid_o is low.
- R8: A new block may be started on the first cycle that busy_o is low after a previous block, and it gives a correct, independent result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin encrypting the presented block; ignored while busy |
| key_i | input | 128 | Cipher key, captured on the accepting edge |
| pt_i | input | 128 | Plaintext block, captured on the accepting edge |
| busy_o | output | 1 | Engine is computing or emitting a block |
| out_valid_o | output | 1 | out_word_o holds a ciphertext word |
| out_word_o | output | 32 | Ciphertext word, most significant word first |

## Verification
The assertions take for granted that start_i is a single-cycle pulse whenever busy_o is low. They also assume key_i and pt_i are stable only on the accepting edge, so after capture nothing downstream depends on them. The stimulus raises start_i for exactly one cycle when the engine is idle, except for one deliberate pulse injected mid-run with different key and data. That pulse must leave the output cadence and the ciphertext untouched. Blocks are issued back to back, so every start lands on the first idle cycle.

// File: rtl/aes_col_pkg.sv
package aes_col_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned NCOL     = 4;
  localparam int unsigned NROUND   = 10;
  localparam int unsigned BLK_W    = WORD_W * NCOL;
  localparam int unsigned LATENCY  = NROUND * NCOL + NCOL;

  typedef enum logic [1:0] {PH_IDLE, PH_RUN, PH_OUT} phase_e;

  function automatic logic [7:0] gf_xtime(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p;
    logic [7:0] x;
    p = '0;
    x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p = p ^ x;
      x = gf_xtime(x);
    end
    return p;
  endfunction

  // inverse as a^254, then affine map
  function automatic logic [7:0] sbox_f(input logic [7:0] a);
    logic [7:0] r;
    logic [7:0] e;
    e = 8'hfe;
    r = 8'h01;
    for (int i = 7; i >= 0; i--) begin
      r = gf_mul(r, r);
      if (e[i]) r = gf_mul(r, a);
    end
    return r ^ {r[6:0], r[7]} ^ {r[5:0], r[7:6]} ^ {r[4:0], r[7:5]} ^
           {r[3:0], r[7:4]} ^ 8'h63;
  endfunction
endpackage

// File: rtl/aes_sbox_bank.sv
module aes_sbox_bank #(
  parameter int unsigned LANES = 4
) (
  input  logic [8*LANES-1:0] in_i,
  output logic [8*LANES-1:0] out_o
);
  import aes_col_pkg::*;
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign out_o[8*l +: 8] = sbox_f(in_i[8*l +: 8]);
  end
endmodule

// File: rtl/aes_col_unit.sv
module aes_col_unit (
  input  logic [31:0] sel_i,
  input  logic        last_i,
  input  logic [31:0] rk_i,
  output logic [31:0] col_o
);
  import aes_col_pkg::*;
  logic [31:0] sub;
  logic [7:0]  b0, b1, b2, b3;
  logic [31:0] mixed;

  aes_sbox_bank #(.LANES(4)) u_sb (.in_i(sel_i), .out_o(sub));

  assign {b0, b1, b2, b3} = sub;
  assign mixed = {gf_xtime(b0) ^ gf_xtime(b1) ^ b1 ^ b2 ^ b3,
                  b0 ^ gf_xtime(b1) ^ gf_xtime(b2) ^ b2 ^ b3,
                  b0 ^ b1 ^ gf_xtime(b2) ^ gf_xtime(b3) ^ b3,
                  gf_xtime(b0) ^ b0 ^ b1 ^ b2 ^ gf_xtime(b3)};
  assign col_o = (last_i ? sub : mixed) ^ rk_i;
endmodule

// File: rtl/aes_key_word.sv
module aes_key_word (
  input  logic [127:0] kw_i,
  input  logic [1:0]   col_i,
  input  logic [7:0]   rcon_i,
  output logic [31:0]  nw_o
);
  logic [31:0] w [4];
  logic [31:0] rot, sub, prev;

  for (genvar i = 0; i < 4; i++) begin : g_w
    assign w[i] = kw_i[127-32*i -: 32];
  end

  assign rot = {w[3][23:0], w[3][31:24]};
  aes_sbox_bank #(.LANES(4)) u_sb (.in_i(rot), .out_o(sub));

  // words before col_i already hold this round's values
  assign prev = (col_i == 2'd0) ? (sub ^ {rcon_i, 24'h0}) : w[col_i - 2'd1];
  assign nw_o = w[col_i] ^ prev;
endmodule

// File: rtl/aes_col_core.sv
module aes_col_core
  import aes_col_pkg::*;
#(
  parameter int unsigned KEY_W = 128
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [KEY_W-1:0]  key_i,
  input  logic [BLK_W-1:0]  pt_i,
  output logic              busy_o,
  output logic              out_valid_o,
  output logic [WORD_W-1:0] out_word_o
);
  localparam int unsigned CW = $clog2(NCOL);
  localparam int unsigned RW = $clog2(NROUND);

  phase_e          phase_q;
  logic [CW-1:0]   col_q;
  logic [RW-1:0]   rnd_q;
  logic [7:0]      rcon_q;
  logic [WORD_W-1:0] st_q  [NCOL];
  logic [WORD_W-1:0] sh_q  [NCOL-1];
  logic [WORD_W-1:0] key_q [NCOL];

  logic [WORD_W-1:0] sel, rk_w, new_col;
  logic [KEY_W-1:0]  key_flat;
  logic              last_rnd;

  assign last_rnd = (rnd_q == RW'(NROUND - 1));
  assign key_flat = {key_q[0], key_q[1], key_q[2], key_q[3]};

  // diagonal pick: row r from column col+r
  for (genvar r = 0; r < NCOL; r++) begin : g_sel
    logic [CW-1:0] src;
    assign src = col_q + CW'(r);
    assign sel[WORD_W-1-8*r -: 8] = st_q[src][WORD_W-1-8*r -: 8];
  end

  aes_key_word u_key (
    .kw_i(key_flat), .col_i(col_q), .rcon_i(rcon_q), .nw_o(rk_w)
  );

  aes_col_unit u_col (
    .sel_i(sel), .last_i(last_rnd), .rk_i(rk_w), .col_o(new_col)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      col_q   <= '0;
      rnd_q   <= '0;
      rcon_q  <= 8'h01;
      for (int i = 0; i < NCOL; i++) begin
        st_q[i]  <= '0;
        key_q[i] <= '0;
      end
      for (int i = 0; i < NCOL - 1; i++) sh_q[i] <= '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: if (start_i) begin
          for (int i = 0; i < NCOL; i++) begin
            st_q[i]  <= pt_i[BLK_W-1-WORD_W*i -: WORD_W] ^ key_i[KEY_W-1-WORD_W*i -: WORD_W];
            key_q[i] <= key_i[KEY_W-1-WORD_W*i -: WORD_W];
          end
          col_q   <= '0;
          rnd_q   <= '0;
          rcon_q  <= 8'h01;
          phase_q <= PH_RUN;
        end
        PH_RUN: begin
          key_q[col_q] <= rk_w;
          col_q        <= col_q + 1'b1;
          if (col_q != CW'(NCOL - 1)) begin
            sh_q[col_q] <= new_col;
          end else begin
            for (int i = 0; i < NCOL - 1; i++) st_q[i] <= sh_q[i];
            st_q[NCOL-1] <= new_col;
            rcon_q <= gf_xtime(rcon_q);
            rnd_q  <= rnd_q + 1'b1;
            if (last_rnd) phase_q <= PH_OUT;
          end
        end
        PH_OUT: begin
          col_q <= col_q + 1'b1;
          if (col_q == CW'(NCOL - 1)) phase_q <= PH_IDLE;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign busy_o      = (phase_q != PH_IDLE);
  assign out_valid_o = (phase_q == PH_OUT);
  assign out_word_o  = out_valid_o ? st_q[col_q] : '0;
endmodule

// File: rtl/aes_col_core_chk.sv
module aes_col_core_chk
  import aes_col_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              busy_o,
  input logic              out_valid_o,
  input logic [WORD_W-1:0] out_word_o
);
  localparam int unsigned FIRST_OUT = NROUND * NCOL;
  logic [6:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (start_i && !busy_o) cnt_q <= '0;
    else if (busy_o)             cnt_q <= cnt_q + 1'b1;
  end

  assert_idle_after_reset_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (!busy_o && !out_valid_o));

  assert_start_accepted_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);

  assert_busy_ends_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && cnt_q == 7'(LATENCY - 1)) |=> !busy_o);

  assert_valid_window_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (out_valid_o == (cnt_q >= 7'(FIRST_OUT))));

  assert_valid_needs_busy_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> busy_o);

  assert_no_restart_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && cnt_q < 7'(FIRST_OUT - 1)) |=> (busy_o && !out_valid_o));

  assert_word_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> (out_word_o == '0));
endmodule

bind aes_col_core aes_col_core_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .busy_o(busy_o),
  .out_valid_o(out_valid_o), .out_word_o(out_word_o)
);

// File: tb/aes_col_core_tb_top.sv
module aes_col_core_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         start_i = 1'b0;
  logic [127:0] key_i = '0;
  logic [127:0] pt_i = '0;
  logic         busy_o, out_valid_o;
  logic [31:0]  out_word_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] sb [256];
  logic [31:0] rng = 32'h1234_5678;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  aes_col_core dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .key_i(key_i),
    .pt_i(pt_i), .busy_o(busy_o), .out_valid_o(out_valid_o), .out_word_o(out_word_o)
  );

  function automatic logic [7:0] xt(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  // substitution table from exp/log tables over generator 3
  task automatic build_sbox();
    logic [7:0] ex [256];
    int lg [256];
    logic [7:0] p, b, s;
    p = 8'h01;
    for (int i = 0; i < 255; i++) begin
      ex[i] = p;
      lg[p] = i;
      p = p ^ xt(p);
    end
    for (int x = 0; x < 256; x++) begin
      b = (x == 0) ? 8'h00 : ex[(255 - lg[x]) % 255];
      s = 8'h63;
      for (int k = 0; k < 5; k++) s = s ^ ((b << k) | (b >> (8 - k)));
      sb[x] = s;
    end
  endtask

  function automatic logic [127:0] ref_enc(input logic [127:0] k, input logic [127:0] p);
    logic [7:0]  s [16];
    logic [7:0]  t [16];
    logic [31:0] w [44];
    logic [31:0] tmp;
    logic [7:0]  rc, a0, a1, a2, a3;
    logic [127:0] res;
    rc = 8'h01;
    for (int i = 0; i < 4; i++) w[i] = k[127-32*i -: 32];
    for (int i = 4; i < 44; i++) begin
      tmp = w[i-1];
      if (i % 4 == 0) begin
        tmp = {sb[tmp[23:16]], sb[tmp[15:8]], sb[tmp[7:0]], sb[tmp[31:24]]} ^ {rc, 24'h0};
        rc = xt(rc);
      end
      w[i] = w[i-4] ^ tmp;
    end
    for (int i = 0; i < 16; i++) s[i] = p[127-8*i -: 8] ^ w[i/4][31-8*(i%4) -: 8];
    for (int rd = 1; rd <= 10; rd++) begin
      for (int c = 0; c < 4; c++)
        for (int r = 0; r < 4; r++) t[4*c+r] = sb[s[4*((c+r)%4)+r]];
      for (int c = 0; c < 4; c++) begin
        a0 = t[4*c]; a1 = t[4*c+1]; a2 = t[4*c+2]; a3 = t[4*c+3];
        if (rd < 10) begin
          s[4*c]   = xt(a0) ^ xt(a1) ^ a1 ^ a2 ^ a3;
          s[4*c+1] = a0 ^ xt(a1) ^ xt(a2) ^ a2 ^ a3;
          s[4*c+2] = a0 ^ a1 ^ xt(a2) ^ xt(a3) ^ a3;
          s[4*c+3] = xt(a0) ^ a0 ^ a1 ^ a2 ^ xt(a3);
        end else begin
          s[4*c] = a0; s[4*c+1] = a1; s[4*c+2] = a2; s[4*c+3] = a3;
        end
        for (int r = 0; r < 4; r++) s[4*c+r] = s[4*c+r] ^ w[4*rd+c][31-8*r -: 8];
      end
    end
    for (int i = 0; i < 16; i++) res[127-8*i -: 8] = s[i];
    return res;
  endfunction

  task automatic check(input logic ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] next_rand128();
    logic [127:0] v;
    for (int i = 0; i < 4; i++) begin
      rng = rng ^ (rng << 13);
      rng = rng ^ (rng >> 17);
      rng = rng ^ (rng << 5);
      v[32*i +: 32] = rng;
    end
    return v;
  endfunction

  // issue one block and follow it cycle by cycle
  task automatic run_block(input logic [127:0] k, input logic [127:0] p,
                           input logic [127:0] exp, input logic inject);
    logic [127:0] got;
    logic timing_ok;
    timing_ok = 1'b1;
    check(!busy_o, "R8", {127'h0, busy_o}, 128'h0);
    key_i = k; pt_i = p; start_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    start_i = 1'b0;
    check(busy_o, "R2", {127'h0, busy_o}, 128'h1);
    for (int c = 1; c < 40; c++) begin
      if (inject && c == 10) begin
        key_i = ~k; pt_i = ~p; start_i = 1'b1;
      end
      @(negedge clk_i);
      start_i = 1'b0;
      if (out_valid_o || !busy_o) timing_ok = 1'b0;
      if (out_word_o != 32'h0) timing_ok = 1'b0;
    end
    check(timing_ok, inject ? "R6" : "R3", {126'h0, busy_o, out_valid_o}, 128'h2);
    for (int wi = 0; wi < 4; wi++) begin
      @(negedge clk_i);
      check(out_valid_o && busy_o, "R3", {126'h0, busy_o, out_valid_o}, 128'h3);
      got[127-32*wi -: 32] = out_word_o;
      check(out_word_o == exp[127-32*wi -: 32], "R4", {96'h0, out_word_o},
            {96'h0, exp[127-32*wi -: 32]});
    end
    check(got == exp, inject ? "R6" : "R5", got, exp);
    @(negedge clk_i);
    check(!busy_o && !out_valid_o, "R2", {126'h0, busy_o, out_valid_o}, 128'h0);
    check(out_word_o == 32'h0, "R7", {96'h0, out_word_o}, 128'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [127:0] k, p;
    build_sbox();
    repeat (3) @(negedge clk_i);
    check(!busy_o && !out_valid_o && out_word_o == 32'h0, "R1",
          {95'h0, busy_o, out_valid_o, out_word_o}, 128'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(!busy_o && !out_valid_o, "R1", {126'h0, busy_o, out_valid_o}, 128'h0);

    // known answers, also cross-checking the bench model (R5)
    k = 128'h000102030405060708090a0b0c0d0e0f;
    p = 128'h00112233445566778899aabbccddeeff;
    check(ref_enc(k, p) == 128'h69c4e0d86a7b0430d8cdb78070b4c55a, "R5",
          ref_enc(k, p), 128'h69c4e0d86a7b0430d8cdb78070b4c55a);
    run_block(k, p, 128'h69c4e0d86a7b0430d8cdb78070b4c55a, 1'b0);
    k = 128'h2b7e151628aed2a6abf7158809cf4f3c;
    p = 128'h3243f6a8885a308d313198a2e0370734;
    run_block(k, p, 128'h3925841d02dc09fbdc118597196a0b32, 1'b1);
    run_block(128'h0, 128'h0, 128'h66e94bd4ef8a2c3b884cfa59ca342b2e, 1'b0);
    run_block({128{1'b1}}, {128{1'b1}}, ref_enc({128{1'b1}}, {128{1'b1}}), 1'b0);

    // back-to-back random blocks against the model (R8)
    for (int v = 0; v < 8; v++) begin
      k = next_rand128();
      p = next_rand128();
      run_block(k, p, ref_enc(k, p), (v == 3));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule